// File: doc/BRIEF.md
# Fat-Tree Least-Common-Ancestor Route Unit

This block computes output ports for one switch in a butterfly fat-tree network-on-chip. Each switch has four downward (child) links and two upward (parent) links. The switch's level and position in the tree, and the number of leaf endpoints, are fixed when the design is elaborated. Each input lane of the switch presents its flits to this unit. For every flit, the unit returns the output port the flit must take one clock later.

A header flit carries an 8-bit destination leaf address. If that leaf lies inside the subtree under this switch, the packet goes down through the child link given by the address digit for this level. Otherwise the packet climbs toward the root through one of the two parent links. The parent link is picked by a fixed bit of the destination, so the route stays deterministic while traffic is spread over both up links. Body and tail flits reuse the port that their header chose. The route is released once the tail flit has been routed.

Buffering, arbitration between lanes and link-level flow control are handled elsewhere. This unit only decides where each flit goes.

Top module: `fattree_route`

## Requirements
- R1: After a synchronous reset, every lane shows out_valid=0 and out_err=0, and no lane holds a route, so a body flit sent as the first flit is reported as an error.
- R2: A head (kind 2'b01) or single (kind 2'b11) flit whose destination d satisfies d < NUM_LEAVES and (d >> 2*LEVEL) == (POSITION >> (LEVEL-1)) is routed down. One cycle later out_valid=1 and out_port = d[2*LEVEL-1:2*LEVEL-2], with values 0..3 meaning child links.
- R3: A head or single flit whose in-range destination lies outside this subtree is routed up. One cycle later out_port = 4 + d[2*LEVEL], where 4 and 5 are the two parent links.
- R4: Body (kind 2'b00) and tail (kind 2'b10) flits of a packet leave through the port their header chose, whatever their destination field holds.
- R5: A tail flit releases the lane's route. A later body or tail flit with no new header gives out_err=1 and out_valid=0.
- R6: A single flit is routed like a head but holds no route afterwards.
- R7: A head or single flit with destination >= NUM_LEAVES gives out_err=1 and out_valid=0, and leaves the lane with no route.
- R8: Each lane keeps its own route. Routes held on different lanes, and flits presented on several lanes in the same cycle, do not affect one another.
- R9: In a cycle with in_valid=0, the lane gives out_valid=0 and out_err=0 one cycle later, and keeps any route it holds.
- R10: A head flit that arrives while a route is held replaces that route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_IN | A flit is presented on the lane |
| in_kind | input | 2*NUM_IN | Flit kind per lane: 00 body, 01 head, 10 tail, 11 single |
| in_dest | input | ADDR_W*NUM_IN | Destination leaf address per lane (used on head/single) |
| out_valid | output | NUM_IN | Registered: lane's last flit was routed |
| out_err | output | NUM_IN | Registered: lane's last flit could not be routed |
| out_port | output | 3*NUM_IN | Registered output port per lane: 0..3 child, 4..5 parent |

## Verification
The hardest state to reach from the ports is a lane that has lost its route without seeing a tail. This happens when a header is rejected as out of range, or after a single flit. A stray body flit must then be flagged, not sent along a stale route. The stimulus first builds a live route on a lane, then sends a rejected or single-flit header on that same lane, then a body flit. It also overlaps packets on two lanes and inserts idle cycles, so that a held route is shown to survive gaps and to stay private to its own lane.

// File: rtl/fattree_route_pkg.sv
package fattree_route_pkg;
  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_HEAD = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  localparam int PORT_W       = 3;
  localparam int CHILD_PORTS  = 4;
  localparam int PARENT_PORTS = 2;
  localparam logic [PORT_W-1:0] UP_BASE = 3'd4;
endpackage

// File: rtl/fattree_route_calc.sv
module fattree_route_calc
  import fattree_route_pkg::*;
#(
  parameter int LEVEL      = 2,
  parameter int SUBTREE    = 1,
  parameter int NUM_LEAVES = 64,
  parameter int ADDR_W     = 8
) (
  input  logic [ADDR_W-1:0] dest,
  output logic              hit,
  output logic              bad,
  output logic [PORT_W-1:0] port
);
  localparam int SHIFT   = 2 * LEVEL;
  localparam int DIG_LO  = SHIFT - 2;
  localparam int PAR_BIT = SHIFT;
  localparam logic [ADDR_W:0]   LEAF_LIM = NUM_LEAVES[ADDR_W:0];
  localparam logic [ADDR_W-1:0] SUB_V    = SUBTREE[ADDR_W-1:0];

  logic [1:0] digit;
  logic       up_sel;

  assign digit = dest[DIG_LO +: 2];

  generate
    if (PAR_BIT < ADDR_W) begin : g_parbit
      assign up_sel = dest[PAR_BIT];
    end else begin : g_noparbit
      assign up_sel = 1'b0;
    end
  endgenerate

  always_comb begin
    bad  = ({1'b0, dest} >= LEAF_LIM);
    hit  = ((dest >> SHIFT) == SUB_V);
    port = hit ? {1'b0, digit} : (UP_BASE | {2'b00, up_sel});
  end
endmodule

// File: rtl/fattree_route_lane.sv
module fattree_route_lane
  import fattree_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [1:0]        kind,
  input  logic              hit,
  input  logic              bad,
  input  logic [PORT_W-1:0] port_calc,
  output logic              out_valid,
  output logic              out_err,
  output logic [PORT_W-1:0] out_port
);
  flit_kind_e        k;
  logic              active;
  logic [PORT_W-1:0] held;
  logic              is_hdr;

  assign k      = flit_kind_e'(kind);
  assign is_hdr = (k == FK_HEAD) || (k == FK_SOLO);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_port  <= '0;
      active    <= 1'b0;
      held      <= '0;
    end else begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      if (valid) begin
        if (is_hdr) begin
          if (bad) begin
            out_err <= 1'b1;
            active  <= 1'b0;
          end else begin
            out_valid <= 1'b1;
            out_port  <= port_calc;
            held      <= port_calc;
            active    <= (k == FK_HEAD);
          end
        end else if (active) begin
          out_valid <= 1'b1;
          out_port  <= held;
          if (k == FK_TAIL) active <= 1'b0;
        end else begin
          out_err <= 1'b1;
        end
      end
    end
  end

  // R2: in-range header inside subtree leaves by a child link
  a_r2_down_inside: assert property (@(posedge clk) disable iff (rst)
    (valid && is_hdr && !bad && hit) |=> (out_valid && !out_port[2] && out_port[1:0] == $past(port_calc[1:0])));

  // R3: in-range header outside subtree leaves by a parent link
  a_r3_up_outside: assert property (@(posedge clk) disable iff (rst)
    (valid && is_hdr && !bad && !hit) |=> (out_valid && out_port[2] && out_port[1] == 1'b0));

  // R4: continuation flits follow the held route
  a_r4_follow_held: assert property (@(posedge clk) disable iff (rst)
    (valid && !is_hdr && active) |=> (out_valid && out_port == $past(held)));

  // R5: tail releases the route
  a_r5_tail_release: assert property (@(posedge clk) disable iff (rst)
    (valid && k == FK_TAIL) |=> !active);

  // R6: a single flit holds nothing afterwards
  a_r6_solo_no_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && k == FK_SOLO) |=> !active);

  // R7: error and valid never together; bad header leaves no route
  a_r7_err_excl: assert property (@(posedge clk) disable iff (rst)
    out_err |-> !out_valid);
  a_r7_bad_drops: assert property (@(posedge clk) disable iff (rst)
    (valid && is_hdr && bad) |=> (out_err && !active));

  // R9: idle cycle gives a quiet output and keeps the route
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (!out_valid && !out_err && $stable(active) && $stable(held)));
endmodule

// File: rtl/fattree_route.sv
module fattree_route
  import fattree_route_pkg::*;
#(
  parameter int LEVEL      = 2,
  parameter int POSITION   = 3,
  parameter int NUM_LEAVES = 64,
  parameter int ADDR_W     = 8,
  parameter int NUM_IN     = CHILD_PORTS + PARENT_PORTS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_IN-1:0]          in_valid,
  input  logic [2*NUM_IN-1:0]        in_kind,
  input  logic [ADDR_W*NUM_IN-1:0]   in_dest,
  output logic [NUM_IN-1:0]          out_valid,
  output logic [NUM_IN-1:0]          out_err,
  output logic [PORT_W*NUM_IN-1:0]   out_port
);
  localparam int SUBTREE = POSITION >> (LEVEL - 1);

  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
      logic              hit;
      logic              bad;
      logic [PORT_W-1:0] pc;

      fattree_route_calc #(
        .LEVEL(LEVEL), .SUBTREE(SUBTREE),
        .NUM_LEAVES(NUM_LEAVES), .ADDR_W(ADDR_W)
      ) u_calc (
        .dest (in_dest[i*ADDR_W +: ADDR_W]),
        .hit  (hit),
        .bad  (bad),
        .port (pc)
      );

      fattree_route_lane u_lane (
        .clk       (clk),
        .rst       (rst),
        .valid     (in_valid[i]),
        .kind      (in_kind[i*2 +: 2]),
        .hit       (hit),
        .bad       (bad),
        .port_calc (pc),
        .out_valid (out_valid[i]),
        .out_err   (out_err[i]),
        .out_port  (out_port[i*PORT_W +: PORT_W])
      );
    end
  endgenerate
endmodule

// File: tb/fattree_route_test.sv
module fattree_route_test;
  localparam int NI = 6;
  localparam int AW = 8;
  localparam int NL = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NI-1:0]     in_valid = '0;
  logic [2*NI-1:0]   in_kind  = '0;
  logic [AW*NI-1:0]  in_dest  = '0;
  logic [NI-1:0]     out_valid;
  logic [NI-1:0]     out_err;
  logic [3*NI-1:0]   out_port;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] KB = 2'b00, KH = 2'b01, KT = 2'b10, KS = 2'b11;

  fattree_route #(.LEVEL(2), .POSITION(3), .NUM_LEAVES(NL), .ADDR_W(AW), .NUM_IN(NI)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_dest(in_dest),
    .out_valid(out_valid), .out_err(out_err), .out_port(out_port)
  );

  always #2 clk = ~clk;

  // Expected port for level 2, position 3: subtree holds leaves 16..31
  function automatic int exp_port(int d);
    if ((d / 16) == 1) return (d / 4) % 4;
    return 4 + ((d / 16) % 2);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(int lane, logic [1:0] kind, int d);
    in_valid[lane]         = 1'b1;
    in_kind[lane*2 +: 2]   = kind;
    in_dest[lane*AW +: AW] = d[AW-1:0];
  endtask

  task automatic step();
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic expect_route(string req, int lane, int port);
    chk(req, {31'd0, out_valid[lane]}, 1);
    chk(req, {31'd0, out_err[lane]}, 0);
    chk(req, {29'd0, out_port[lane*3 +: 3]}, port);
  endtask

  task automatic expect_err(string req, int lane);
    chk(req, {31'd0, out_valid[lane]}, 0);
    chk(req, {31'd0, out_err[lane]}, 1);
  endtask

  task automatic t_reset();
    chk("R1 valid", {26'd0, out_valid}, 0);
    chk("R1 err", {26'd0, out_err}, 0);
    put(1, KB, 20); step();
    expect_err("R1 no route", 1);
  endtask

  task automatic t_down();
    int ds[3] = '{22, 31, 16};
    foreach (ds[j]) begin
      put(0, KS, ds[j]); step();
      expect_route("R2 down", 0, exp_port(ds[j]));
    end
    put(0, KB, 22); step();
    expect_err("R6 solo holds nothing", 0);
  endtask

  task automatic t_up();
    int ds[4] = '{5, 40, 50, 63};
    foreach (ds[j]) begin
      put(4, KS, ds[j]); step();
      expect_route("R3 up", 4, exp_port(ds[j]));
    end
  endtask

  task automatic t_packet();
    put(2, KH, 20); step();
    expect_route("R2 head", 2, 1);
    put(2, KB, 8'h40); step();
    expect_route("R4 body", 2, 1);
    put(2, KT, 3); step();
    expect_route("R4 tail", 2, 1);
    put(2, KB, 20); step();
    expect_err("R5 after tail", 2);
  endtask

  task automatic t_bad();
    put(3, KH, 24); step();
    expect_route("R10 setup", 3, 2);
    put(3, KH, 64); step();
    expect_err("R7 bad head", 3);
    put(3, KB, 24); step();
    expect_err("R7 route dropped", 3);
    put(3, KS, 200); step();
    expect_err("R7 bad solo", 3);
  endtask

  task automatic t_parallel();
    put(0, KH, 17); put(5, KH, 60); step();
    expect_route("R8 lane0", 0, 0);
    expect_route("R8 lane5", 5, 5);
    step();
    chk("R9 idle valid", {26'd0, out_valid}, 0);
    chk("R9 idle err", {26'd0, out_err}, 0);
    put(0, KB, 60); put(5, KT, 17); step();
    expect_route("R9 kept lane0", 0, 0);
    expect_route("R8 lane5 tail", 5, 5);
    put(0, KT, 0); step();
    expect_route("R8 lane0 tail", 0, 0);
  endtask

  task automatic t_replace();
    put(3, KH, 24); step();
    expect_route("R10 first", 3, 2);
    put(3, KH, 8); step();
    expect_route("R10 second", 3, 4);
    put(3, KB, 24); step();
    expect_route("R10 body follows new", 3, 4);
    put(3, KT, 24); step();
    expect_route("R10 tail", 3, 4);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_down();
    t_up();
    t_packet();
    t_bad();
    t_parallel();
    t_replace();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule